// File: doc/BRIEF.md
# Write-Once Byte Store with Mode Decode

This block is a synthesizable model of a byte-wide memory that can be written once and cleared only by an erase. It is sized 32K x 8 when `ADDR_W` is 15; the default build uses a smaller array. Two active-low strobes select the operation: a chip select `ce_n` and an output strobe `oe_n`. Two boolean flags stand in for analog conditions. `vpp_on` means the programming voltage is present. `id_hv` means an over-voltage sits on the identifier address line, which is bit `ID_BIT` (default 9).

The decoded operation can be a read, output disable, standby, program, program inhibit, program verify or identifier readout. Each operation is captured at a clock edge. Results appear on `dq_out` and `dq_oe` one cycle after the edge that sampled the inputs.

A program pulse can only turn 1 bits into 0 bits. The synchronous `erase` input returns every location to all ones. The identifier readout returns a maker byte and a part byte, and both carry odd parity in bit 7. All pins are plain level controls. Every clock edge takes a fresh operation, so there is no handshake and no back-pressure.

Top module: `otp_byte_store`

## Requirements
- R1: While `erase` is high at a clock edge, every location becomes FFh and the outputs float on the next cycle. Erase overrides every other input.
- R2: A read is selected by `ce_n`=0, `oe_n`=0, `vpp_on`=0 and `id_hv`=0 at an edge. It drives the byte stored at `addr` on `dq_out` with `dq_oe`=1 in the following cycle.
- R3: With `vpp_on`=0 and `ce_n`=1 (standby), `dq_oe` is 0 whatever `oe_n` and `id_hv` are. Whenever `dq_oe` is 0, `dq_out` reads 00h.
- R4: With `vpp_on`=0, `ce_n`=0 and `oe_n`=1 (output disable), `dq_oe` is 0.
- R5: A program is selected by `vpp_on`=1, `ce_n`=0 and `oe_n`=1. The stored byte at `addr` becomes its old value ANDed with `din`, so no bit rises from 0 to 1, and the outputs float.
- R6: With `vpp_on`=1, `ce_n`=1 and `oe_n`=1 (inhibit), nothing is written and the outputs float.
- R7: With `vpp_on`=1, `ce_n`=1 and `oe_n`=0 (verify), the stored byte at `addr` is driven out with `dq_oe`=1 in the following cycle.
- R8: With `id_hv`=1, `vpp_on`=0, `ce_n`=0, `oe_n`=0, and every address bit other than bit 0 and bit `ID_BIT` at 0, the block outputs an identifier. Bit 0 = 0 gives the maker code 01h and bit 0 = 1 gives the part code 10h. Each code has odd parity over all eight bits, with bit 7 as the parity bit.
- R9: In the identifier condition of R8, if any address bit other than bit 0 and bit `ID_BIT` is 1, the outputs float.
- R10: While `rst_n` is low, `dq_oe` is 0 and `dq_out` is 00h. Stored bytes survive reset.
- R11: With `vpp_on`=1, `ce_n`=0 and `oe_n`=0, nothing is written and the outputs float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output stage |
| erase | input | 1 | Synchronous erase to all ones |
| vpp_on | input | 1 | Programming voltage present |
| id_hv | input | 1 | Over-voltage on identifier address line |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Program data |
| dq_out | output | DATA_W | Output byte, 00h while floating |
| dq_oe | output | 1 | Output driven |

## Verification
The bench programs the same byte several times with different patterns. Comparing a first pattern, a second pattern that clears further bits, and an all-ones pattern shows whether programming ANDs, overwrites or can raise bits. Each strobe and flag combination is applied at an address holding a known non-FF byte. This tells a float apart from a drive, and a blocked write apart from an accepted one. Identifier reads are tried with a clean address, with stray bits set low and high in the address, and without the flag. These patterns separate the code path, the float path and the plain array read.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_READ,
    OP_PROG,
    OP_VERIFY,
    OP_IDREAD,
    OP_ERASE
  } op_e;

  // 7 payload bits plus bit 7 chosen to make the byte's ones count odd
  function automatic logic [7:0] odd_parity_byte(input logic [6:0] v);
    return {~(^v), v};
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int ID_BIT = 9
) (
  input  logic              erase,
  input  logic              vpp_on,
  input  logic              id_hv,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op
);

  localparam logic [ADDR_W-1:0] KEEP_MASK =
    (ADDR_W'(1) << ID_BIT) | ADDR_W'(1);

  logic id_clean;
  assign id_clean = ((addr & ~KEEP_MASK) == '0);

  always_comb begin
    if (erase) begin
      op = OP_ERASE;
    end else if (vpp_on) begin
      if (ce_n) op = oe_n ? OP_IDLE : OP_VERIFY;
      else      op = oe_n ? OP_PROG : OP_IDLE;
    end else if (ce_n || oe_n) begin
      op = OP_IDLE;
    end else if (id_hv) begin
      op = id_clean ? OP_IDREAD : OP_IDLE;
    end else begin
      op = OP_READ;
    end
  end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[addr] <= mem[addr] & din;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[addr];
  end

  // R5: a program pulse never raises a cleared bit
  p_no_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> ((mem[$past(addr)] & ~$past(mem[addr])) == '0));

  // R1: the erased location holds all ones
  p_erase_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (mem[$past(addr)] == '1));

endmodule

// File: rtl/otp_id_source.sv
module otp_id_source
  import otp_pkg::*;
#(
  parameter logic [6:0] MFR7 = 7'h01,
  parameter logic [6:0] DEV7 = 7'h10
) (
  input  logic       sel_dev,
  output logic [7:0] code
);

  localparam logic [7:0] MFR_CODE = odd_parity_byte(MFR7);
  localparam logic [7:0] DEV_CODE = odd_parity_byte(DEV7);

  assign code = sel_dev ? DEV_CODE : MFR_CODE;

  // R8: every identifier byte has odd parity
  always_comb begin
    if (!$isunknown(sel_dev)) begin
      p_id_parity_r8: assert (^code == 1'b1);
    end
  end

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
  import otp_pkg::*;
#(
  parameter int         ADDR_W = 11,
  parameter int         DATA_W = 8,
  parameter int         ID_BIT = 9,
  parameter logic [6:0] MFR7   = 7'h01,
  parameter logic [6:0] DEV7   = 7'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              vpp_on,
  input  logic              id_hv,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam logic [ADDR_W-1:0] KEEP_MASK =
    (ADDR_W'(1) << ID_BIT) | ADDR_W'(1);

  op_e              op, op_q;
  logic [DATA_W-1:0] rdata;
  logic [7:0]        id_code;
  logic [DATA_W-1:0] id_q;

  otp_mode_decode #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) u_dec (
    .erase (erase),
    .vpp_on(vpp_on),
    .id_hv (id_hv),
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .addr  (addr),
    .op    (op)
  );

  otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk  (clk),
    .rst_n(rst_n),
    .erase(erase),
    .wr_en(op == OP_PROG),
    .rd_en((op == OP_READ) || (op == OP_VERIFY)),
    .addr (addr),
    .din  (din),
    .rdata(rdata)
  );

  otp_id_source #(.MFR7(MFR7), .DEV7(DEV7)) u_id (
    .sel_dev(addr[0]),
    .code   (id_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_IDLE;
      id_q <= '0;
    end else begin
      op_q <= op;
      id_q <= DATA_W'(id_code);
    end
  end

  always_comb begin
    dq_oe  = 1'b0;
    dq_out = '0;
    unique case (op_q)
      OP_READ, OP_VERIFY: begin dq_oe = 1'b1; dq_out = rdata; end
      OP_IDREAD:          begin dq_oe = 1'b1; dq_out = id_q;  end
      default:            ;
    endcase
  end

  // R2: a plain read drives the bus next cycle
  p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase && !vpp_on && !id_hv && !ce_n && !oe_n) |=> dq_oe);

  // R3: standby floats regardless of the output strobe
  p_standby_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_on && ce_n) |=> !dq_oe);

  // R4: output disable floats
  p_disable_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_on && !ce_n && oe_n) |=> !dq_oe);

  // R5: program floats the bus
  p_prog_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_on && !ce_n && oe_n) |=> !dq_oe);

  // R7: verify drives the bus unless erasing
  p_verify_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase && vpp_on && ce_n && !oe_n) |=> dq_oe);

  // R9: stray address bits in identifier mode float the bus
  p_id_stray_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_on && id_hv && !ce_n && !oe_n && ((addr & ~KEEP_MASK) != '0))
      |=> !dq_oe);

endmodule

// File: tb/otp_byte_store_tb.sv
`timescale 1ns/1ps
module otp_byte_store_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        erase = 1'b0, vpp_on = 1'b0, id_hv = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  otp_byte_store u_dut (
    .clk(clk), .rst_n(rst_n), .erase(erase), .vpp_on(vpp_on), .id_hv(id_hv),
    .ce_n(ce_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // [36:33] req, [32] erase, [31] vpp, [30] id_hv, [29] ce_n, [28] oe_n,
  // [27:17] addr, [16:9] din, [8] expected oe, [7:0] expected byte
  function automatic logic [36:0] mk(input logic [3:0] rq, input logic er,
      input logic vp, input logic hv, input logic ce, input logic oe,
      input logic [10:0] a, input logic [7:0] d, input logic eo,
      input logic [7:0] ed);
    return {rq, er, vp, hv, ce, oe, a, d, eo, ed};
  endfunction

  localparam int NV = 27;
  localparam logic [36:0] VEC [NV] = '{
    mk(4'd1,  1,0,0,1,1, 11'h000, 8'h00, 0, 8'h00), // R1 erase
    mk(4'd1,  0,0,0,0,0, 11'h005, 8'h00, 1, 8'hFF), // R1 blank
    mk(4'd1,  0,0,0,0,0, 11'h7FF, 8'h00, 1, 8'hFF), // R1 blank top
    mk(4'd5,  0,1,0,0,1, 11'h005, 8'hA5, 0, 8'h00), // R5 program
    mk(4'd5,  0,0,0,0,0, 11'h005, 8'h00, 1, 8'hA5), // R5
    mk(4'd5,  0,1,0,0,1, 11'h005, 8'hF0, 0, 8'h00), // R5 clear more
    mk(4'd5,  0,0,0,0,0, 11'h005, 8'h00, 1, 8'hA0), // R5 AND result
    mk(4'd5,  0,1,0,0,1, 11'h005, 8'hFF, 0, 8'h00), // R5 try raise
    mk(4'd5,  0,0,0,0,0, 11'h005, 8'h00, 1, 8'hA0), // R5 no raise
    mk(4'd5,  0,1,0,0,1, 11'h123, 8'h3C, 0, 8'h00), // R5
    mk(4'd2,  0,0,0,0,0, 11'h123, 8'h00, 1, 8'h3C), // R2 read
    mk(4'd3,  0,0,0,1,0, 11'h123, 8'h00, 0, 8'h00), // R3 standby oe low
    mk(4'd3,  0,0,0,1,1, 11'h123, 8'h00, 0, 8'h00), // R3 standby oe high
    mk(4'd4,  0,0,0,0,1, 11'h123, 8'h00, 0, 8'h00), // R4 disable
    mk(4'd6,  0,1,0,1,1, 11'h123, 8'h00, 0, 8'h00), // R6 inhibit
    mk(4'd6,  0,0,0,0,0, 11'h123, 8'h00, 1, 8'h3C), // R6 unchanged
    mk(4'd7,  0,1,0,1,0, 11'h123, 8'h00, 1, 8'h3C), // R7 verify
    mk(4'd11, 0,1,0,0,0, 11'h123, 8'h00, 0, 8'h00), // R11 float
    mk(4'd11, 0,0,0,0,0, 11'h123, 8'h00, 1, 8'h3C), // R11 unchanged
    mk(4'd8,  0,0,1,0,0, 11'h200, 8'h00, 1, 8'h01), // R8 maker
    mk(4'd8,  0,0,1,0,0, 11'h201, 8'h00, 1, 8'h10), // R8 part
    mk(4'd9,  0,0,1,0,0, 11'h204, 8'h00, 0, 8'h00), // R9 stray low bit
    mk(4'd9,  0,0,1,0,0, 11'h481, 8'h00, 0, 8'h00), // R9 stray high bit
    mk(4'd3,  0,0,1,1,0, 11'h200, 8'h00, 0, 8'h00), // R3 id in standby
    mk(4'd1,  1,0,0,0,0, 11'h123, 8'h00, 0, 8'h00), // R1 erase overrides read
    mk(4'd1,  0,0,0,0,0, 11'h123, 8'h00, 1, 8'hFF), // R1 erased
    mk(4'd2,  0,0,0,0,0, 11'h200, 8'h00, 1, 8'hFF)  // R2 no flag, array read
  };

  task automatic check(input string rq, input logic eo, input logic [7:0] ed);
    checks++;
    if (dq_oe !== eo || dq_out !== ed) begin
      fails++;
      $display("FAIL %s: dq_oe=%0b dq_out=%02h expected dq_oe=%0b dq_out=%02h",
               rq, dq_oe, dq_out, eo, ed);
    end
  endtask

  task automatic drive(input logic er, input logic vp, input logic hv,
      input logic ce, input logic oe, input logic [10:0] a, input logic [7:0] d);
    erase = er; vpp_on = vp; id_hv = hv; ce_n = ce; oe_n = oe; addr = a; din = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", 1'b0, 8'h00);               // R10 reset state
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][32], VEC[i][31], VEC[i][30], VEC[i][29], VEC[i][28],
            VEC[i][27:17], VEC[i][16:9]);
      @(negedge clk);
      check($sformatf("R%0d", VEC[i][36:33]), VEC[i][8], VEC[i][7:0]);
    end

    // R8: parity of both identifier bytes checked at the port
    drive(0, 0, 1, 0, 0, 11'h200, 8'h00);
    @(negedge clk);
    checks++;
    if (^dq_out !== 1'b1) begin
      fails++;
      $display("FAIL R8: maker parity %0b expected 1", ^dq_out);
    end
    drive(0, 0, 1, 0, 0, 11'h201, 8'h00);
    @(negedge clk);
    checks++;
    if (^dq_out !== 1'b1) begin
      fails++;
      $display("FAIL R8: part parity %0b expected 1", ^dq_out);
    end

    // R10: reset mid-run floats the bus, stored data survives
    drive(0, 1, 0, 0, 1, 11'h010, 8'h81);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 11'h010, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", 1'b1, 8'h81);

    drive(0, 0, 0, 1, 1, 11'h000, 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete expected done=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule